// File: doc/BRIEF.md
# Ten-Bit Masked-Address I2C Slave Receiver

This block is the receive side of an I2C slave that answers write transfers carrying 10-bit addresses. The address arrives in two bytes. The first is a fixed header holding the two top address bits and the direction bit. The second holds the eight low address bits. Both bytes are compared against one 8-bit host-owned address register. The host keeps that register loaded with whichever address byte the slave is waiting for. A 5-bit mask turns chosen low-order address bits into don't-care positions for the second byte.

After each address byte that matches, the slave acknowledges it and raises an address-update flag. It then holds SCL low until the host rewrites the address register: the low byte after the header, and the header again after the low byte. Data bytes that follow are acknowledged and copied into a one-byte receive buffer. If the buffer has not been read, the byte is refused and an overflow is recorded. Every acknowledged byte raises a one-cycle interrupt pulse and a sticky interrupt flag.

Both bus lines are sampled through synchronizers in the block's own clock domain. The block drives its open-drain pull-downs through `sda_oe` and `scl_oe`.

Top module: `tsr_slave_rx`

## Requirements
- R1: A first address byte is acknowledged only when bits 7:3 equal 11110, bits 2:1 equal address-register bits 2:1, and bit 0 (direction) is 0. Any other first byte, or a refused second byte, is not acknowledged, and every later byte is ignored until the next START.
- R2: The second address byte is acknowledged when it equals the address register in every bit not masked. Mask bit 0 frees bits 1:0 together, and mask bit k (k = 1..4) frees bit k+1. Bits 7:6 are always compared.
- R3: At the end of the ninth clock of each acknowledged address byte, `upd_flag` rises and `scl_oe` holds SCL low. A host write to the address register (`addr_wr`) clears the flag and releases SCL.
- R4: An acknowledged data byte is copied to `buf_rdata` and sets `buf_full` at the end of its ninth clock. A `buf_rd` pulse clears `buf_full`.
- R5: A data byte that completes while `buf_full` is set is not acknowledged. It sets `overflow` and leaves `buf_rdata` unchanged.
- R6: Each acknowledged byte, whether address or data, gives a one-cycle `byte_irq` pulse and sets `irq_flag`. Refused bytes give neither. `flag_clr` clears `irq_flag` and `overflow`.
- R7: SCL is never held after a data byte. Only a pending address update stretches the clock.
- R8: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. After a STOP, bytes clocked without a new START are not acknowledged. A repeated START restarts at the header byte.
- R9: The acknowledge pull-down on SDA starts and ends only while SCL is low, covering the ninth clock.
- R10: After reset, all flags are 0, `buf_rdata` is 0, and neither bus line is pulled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sensed SCL bus level |
| sda_in | input | 1 | Sensed SDA bus level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low (acknowledge) |
| addr_wr | input | 1 | Host write strobe for the address register |
| addr_wdata | input | 8 | Address byte written by the host |
| mask_cfg | input | 5 | Don't-care mask for the low address byte |
| buf_rd | input | 1 | Host read strobe for the receive buffer |
| flag_clr | input | 1 | Clears interrupt and overflow flags |
| buf_rdata | output | 8 | Receive buffer contents |
| buf_full | output | 1 | Buffer holds an unread byte |
| overflow | output | 1 | A byte was refused because the buffer was full |
| upd_flag | output | 1 | Host must reload the address register |
| irq_flag | output | 1 | Sticky per-byte interrupt flag |
| byte_irq | output | 1 | One-cycle pulse per acknowledged byte |

## Verification
The hardest case to reach from the ports is the second address byte, for two reasons. It is judged only after a matching header, and only after the host has reloaded the address register while the slave holds SCL low. The bench therefore runs a complete two-byte handshake for every mask value. For each mask it flips every low address bit one at a time and predicts the acknowledge from its own mapping of mask bits to address bits. The overflow path is reached by sending two data bytes in a row without reading the buffer.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  localparam int BYTE_W = 8;
  localparam int MASK_W = 5;
  localparam int CNT_W  = 4;
  localparam logic [4:0] HDR_TAG = 5'b11110;

  typedef enum logic [2:0] {ST_IDLE, ST_HI, ST_LO, ST_DATA, ST_SKIP} rx_state_t;
  typedef enum logic [1:0] {EV_NONE, EV_ADDR, EV_DATA, EV_OVF} rx_event_t;

  // Expand the 5-bit mask into per-bit don't-care positions of the low byte.
  function automatic logic [BYTE_W-1:0] dc_bits(input logic [MASK_W-1:0] m);
    logic [BYTE_W-1:0] d;
    d      = '0;
    d[1:0] = {2{m[0]}};
    d[5:2] = m[4:1];
    return d;
  endfunction

  function automatic logic hdr_ok(input logic [BYTE_W-1:0] rx, input logic [BYTE_W-1:0] areg);
    return (rx[7:3] == HDR_TAG) && (rx[2:1] == areg[2:1]) && (rx[0] == 1'b0);
  endfunction

  function automatic logic low_ok(input logic [BYTE_W-1:0] rx, input logic [BYTE_W-1:0] areg,
                                  input logic [MASK_W-1:0] m);
    return ((rx ^ areg) & ~dc_bits(m)) == '0;
  endfunction
endpackage

// File: rtl/tsr_sync.sv
module tsr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tsr_bus_events.sv
module tsr_bus_events #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_p, sda_p;

  tsr_sync #(.STAGES(STAGES)) u_scl (.clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));
  tsr_sync #(.STAGES(STAGES)) u_sda (.clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/tsr_frame.sv
module tsr_frame
  import tsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              byte_done,
  output logic              ack_end,
  output logic              ack_win
);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT  = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_HIGH  = CNT_W'(BYTE_W + 1);

  logic [CNT_W-1:0] bitcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt    <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
      ack_end   <= 1'b0;
      ack_win   <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      ack_end   <= 1'b0;
      if (start_ev || stop_ev) begin
        bitcnt  <= '0;
        ack_win <= 1'b0;
      end else if (scl_rise) begin
        if (bitcnt < ACK_SLOT) begin
          rx_byte   <= {rx_byte[BYTE_W-2:0], sda_s};
          bitcnt    <= bitcnt + 1'b1;
          byte_done <= (bitcnt == LAST_DATA);
        end else if (bitcnt == ACK_SLOT) begin
          bitcnt <= ACK_HIGH;
        end
      end else if (scl_fall) begin
        if (bitcnt == ACK_SLOT) begin
          ack_win <= 1'b1;
        end else if (bitcnt == ACK_HIGH) begin
          ack_win <= 1'b0;
          ack_end <= 1'b1;
          bitcnt  <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/tsr_slave_rx.sv
module tsr_slave_rx
  import tsr_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] ADDR_RST    = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              addr_wr,
  input  logic [BYTE_W-1:0] addr_wdata,
  input  logic [MASK_W-1:0] mask_cfg,
  input  logic              buf_rd,
  input  logic              flag_clr,
  output logic [BYTE_W-1:0] buf_rdata,
  output logic              buf_full,
  output logic              overflow,
  output logic              upd_flag,
  output logic              irq_flag,
  output logic              byte_irq
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic [BYTE_W-1:0] rx_byte;
  logic byte_done, ack_end, ack_win;

  tsr_bus_events #(.STAGES(SYNC_STAGES)) u_ev (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev));

  tsr_frame u_frame (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .rx_byte(rx_byte), .byte_done(byte_done),
    .ack_end(ack_end), .ack_win(ack_win));

  rx_state_t         state;
  rx_event_t         evt_q;
  logic              ack_q;
  logic [BYTE_W-1:0] addr_reg, buf_q;

  // Named events at the end of the ninth clock.
  logic upd_set, buf_load, ovf_set, irq_set;
  assign upd_set  = ack_end && (evt_q == EV_ADDR);
  assign buf_load = ack_end && (evt_q == EV_DATA);
  assign ovf_set  = ack_end && (evt_q == EV_OVF);
  assign irq_set  = upd_set || buf_load;

  // Byte decision and address phase tracking.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      evt_q <= EV_NONE;
      ack_q <= 1'b0;
    end else if (start_ev || stop_ev) begin
      state <= start_ev ? ST_HI : ST_IDLE;
      evt_q <= EV_NONE;
      ack_q <= 1'b0;
    end else if (byte_done) begin
      unique case (state)
        ST_HI: begin
          ack_q <= hdr_ok(rx_byte, addr_reg);
          evt_q <= hdr_ok(rx_byte, addr_reg) ? EV_ADDR : EV_NONE;
          state <= hdr_ok(rx_byte, addr_reg) ? ST_LO : ST_SKIP;
        end
        ST_LO: begin
          ack_q <= low_ok(rx_byte, addr_reg, mask_cfg);
          evt_q <= low_ok(rx_byte, addr_reg, mask_cfg) ? EV_ADDR : EV_NONE;
          state <= low_ok(rx_byte, addr_reg, mask_cfg) ? ST_DATA : ST_SKIP;
        end
        ST_DATA: begin
          ack_q <= !buf_full;
          evt_q <= buf_full ? EV_OVF : EV_DATA;
        end
        default: begin
          ack_q <= 1'b0;
          evt_q <= EV_NONE;
        end
      endcase
    end else if (ack_end) begin
      ack_q <= 1'b0;
      evt_q <= EV_NONE;
    end
  end

  // Host-visible registers and flags.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_reg <= ADDR_RST;
      buf_q    <= '0;
      buf_full <= 1'b0;
      overflow <= 1'b0;
      upd_flag <= 1'b0;
      irq_flag <= 1'b0;
      byte_irq <= 1'b0;
    end else begin
      byte_irq <= irq_set;
      if (addr_wr) addr_reg <= addr_wdata;
      if (upd_set) upd_flag <= 1'b1;
      else if (addr_wr) upd_flag <= 1'b0;
      if (buf_load) begin
        buf_q    <= rx_byte;
        buf_full <= 1'b1;
      end else if (buf_rd) begin
        buf_full <= 1'b0;
      end
      if (ovf_set) overflow <= 1'b1;
      else if (flag_clr) overflow <= 1'b0;
      if (irq_set) irq_flag <= 1'b1;
      else if (flag_clr) irq_flag <= 1'b0;
    end
  end

  assign buf_rdata = buf_q;
  assign sda_oe    = ack_q && ack_win;
  assign scl_oe    = upd_flag;

  AST_NAK_WHEN_IGNORING: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (state != ST_SKIP && state != ST_IDLE)); // R1
  AST_UPD_CLEARED_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_wr && !upd_set) |=> !upd_flag); // R3
  AST_LOAD_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    buf_load |=> buf_full); // R4
  AST_OVF_KEEPS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set |=> $stable(buf_rdata)); // R5
  AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_irq |=> !byte_irq); // R6
  AST_STRETCH_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> (state == ST_LO || state == ST_DATA) && !scl_s); // R7
  AST_ACK_STARTS_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s); // R9
  AST_ACK_ENDS_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> !scl_s); // R9
endmodule

// File: tb/tsr_slave_rx_test.sv
module tsr_slave_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 4;
  localparam logic [7:0] HI = 8'hF4; // 11110, A9:A8 = 10, write
  localparam logic [7:0] LO = 8'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_oe, sda_oe;
  logic addr_wr = 1'b0, buf_rd = 1'b0, flag_clr = 1'b0;
  logic [7:0] addr_wdata = '0;
  logic [4:0] mask_cfg = '0;
  logic [7:0] buf_rdata;
  logic buf_full, overflow, upd_flag, irq_flag, byte_irq;
  logic scl_line, sda_line;
  int n_tests = 0, n_fail = 0, irq_cnt = 0, cyc = 0;

  assign scl_line = m_scl & ~scl_oe;
  assign sda_line = m_sda & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsr_slave_rx uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .addr_wr(addr_wr), .addr_wdata(addr_wdata),
    .mask_cfg(mask_cfg), .buf_rd(buf_rd), .flag_clr(flag_clr), .buf_rdata(buf_rdata),
    .buf_full(buf_full), .overflow(overflow), .upd_flag(upd_flag),
    .irq_flag(irq_flag), .byte_irq(byte_irq));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && byte_irq) irq_cnt <= irq_cnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_high();
    m_scl = 1'b1;
    while (!scl_line) tick(1);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q);
    scl_high(); tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q);
    scl_high(); tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(Q);
      scl_high(); tick(2*Q);
      m_scl = 1'b0; tick(Q);
    end
    m_sda = 1'b1; tick(Q);
    scl_high(); tick(Q);
    acked = !sda_line;
    tick(Q);
    m_scl = 1'b0; tick(2*Q);
  endtask

  task automatic host_addr(input logic [7:0] b);
    addr_wr = 1'b1; addr_wdata = b; tick(1);
    addr_wr = 1'b0; tick(1);
  endtask

  task automatic pulse_rd();  buf_rd = 1'b1;   tick(1); buf_rd = 1'b0;   tick(1); endtask
  task automatic pulse_clr(); flag_clr = 1'b1; tick(1); flag_clr = 1'b0; tick(1); endtask

  // Mask bit that frees address bit k, or -1 when bit k is always compared.
  function automatic int free_bit(input int k);
    if (k <= 1) return 0;
    if (k <= 5) return k - 1;
    return -1;
  endfunction

  initial begin
    logic ack;
    int base;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R10 reset state
    chk("R10 flags", {buf_full, overflow, upd_flag, irq_flag, byte_irq}, 5'b0);
    chk("R10 buffer", buf_rdata, 8'h00);
    chk("R10 lines", {scl_oe, sda_oe}, 2'b00);

    // R3 / R7 / R4 / R5 / R6 full transfer with mask 0
    host_addr(HI);
    bus_start();
    base = irq_cnt;
    send_byte(HI, ack);
    chk("R1 header ack", ack, 1);
    chk("R3 upd after header", upd_flag, 1);
    chk("R3 scl held", scl_oe, 1);
    chk("R6 irq on header", irq_cnt - base, 1);
    m_scl = 1'b1; tick(6);
    chk("R3 line stays low", scl_line, 0);
    m_scl = 1'b0; tick(2);
    host_addr(LO);
    chk("R3 write clears upd", {upd_flag, scl_oe}, 2'b00);
    send_byte(LO, ack);
    chk("R2 exact low ack", ack, 1);
    chk("R3 upd after low", upd_flag, 1);
    host_addr(HI);
    send_byte(8'hA5, ack);
    chk("R4 data ack", ack, 1);
    chk("R4 buffer", buf_rdata, 8'hA5);
    chk("R4 full", buf_full, 1);
    chk("R6 irq flag", irq_flag, 1);
    chk("R6 irq count", irq_cnt - base, 3);
    tick(6);
    chk("R7 no data stretch", {scl_oe, upd_flag}, 2'b00);
    send_byte(8'h3C, ack);
    chk("R5 overflow nak", ack, 0);
    chk("R5 overflow flag", overflow, 1);
    chk("R5 buffer kept", buf_rdata, 8'hA5);
    chk("R6 no irq on refused", irq_cnt - base, 3);
    pulse_clr();
    chk("R6 clear flags", {irq_flag, overflow}, 2'b00);
    pulse_rd();
    chk("R4 read clears full", buf_full, 0);
    send_byte(8'h77, ack);
    chk("R4 second data ack", ack, 1);
    chk("R4 second buffer", buf_rdata, 8'h77);
    pulse_rd();
    // R8 repeated start restarts at header
    bus_start();
    send_byte(HI, ack);
    chk("R8 restart header ack", ack, 1);
    host_addr(LO);
    bus_stop();
    // R8 bytes after stop without start are ignored
    base = irq_cnt;
    m_scl = 1'b0; tick(Q);
    send_byte(HI, ack);
    chk("R8 no start nak", ack, 0);
    chk("R8 no irq", irq_cnt - base, 0);
    host_addr(HI);
    bus_stop();

    // R1 wrong direction bit, then ignored until START
    bus_start();
    send_byte(8'hF5, ack);
    chk("R1 read bit nak", ack, 0);
    chk("R1 no upd", upd_flag, 0);
    send_byte(HI, ack);
    chk("R1 ignored until start", ack, 0);
    bus_start();
    send_byte(8'hF2, ack);
    chk("R1 upper bits nak", ack, 0);
    bus_start();
    send_byte(8'hE4, ack);
    chk("R1 bad tag nak", ack, 0);
    chk("R1 no irq", irq_cnt - base, 0);
    bus_stop();

    // R2 sweep: every mask value, every single-bit flip of the low byte
    for (int m = 0; m < 32; m++) begin
      mask_cfg = 5'(m);
      for (int k = 0; k < 8; k++) begin
        logic exp_ack;
        int fb;
        fb = free_bit(k);
        exp_ack = (fb >= 0) ? ((m >> fb) & 1) == 1 : 1'b0;
        host_addr(HI);
        bus_start();
        send_byte(HI, ack);
        chk("R1 sweep header", ack, 1);
        host_addr(LO);
        base = irq_cnt;
        send_byte(LO ^ (8'h01 << k), ack);
        chk("R2 masked compare", ack, exp_ack);
        chk("R3 upd follows match", upd_flag, exp_ack);
        chk("R6 irq follows match", irq_cnt - base, exp_ack ? 1 : 0);
        if (ack) host_addr(HI);
        bus_stop();
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wait (cyc >= 190000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected<190000 cycles", cyc);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule